// File: doc/BRIEF.md
# Vector Register Memory Transfer Unit

This block moves one element between a 128-bit vector register and a memory port that is 64 bits wide. A single start pulse supplies the direction (load or store), the element size as a log2 byte count, the byte order and the byte address. On a store the unit takes a copy of the register value at start. It then issues one memory beat, or two beats for a 16-byte element. On a load it collects the returned beats, zero-extends the element to the full register width, and writes the register once at the end.

Elements of 1, 2, 4 and 8 bytes travel in a single beat. The element sits in the byte lanes selected by the low address bits, rounded down to the element alignment. A 16-byte element is split into two 64-bit beats: the low half goes to the given address and the high half to the given address plus 8. The big-endian option reverses the byte order inside each element, or inside each 64-bit half for a 16-byte element. A size code above 4 is rejected without any memory traffic.

Top module: `vreg_mem_xfer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mem_req_o, mem_we_o, reg_we_o, busy_o, done_o and err_o are all low.
- R2: A store with size code s in 0..3 issues exactly one beat with mem_we_o=1 and mem_addr_o equal to addr_i. mem_be_o has 2^s contiguous ones starting at lane off, where off is addr_i[2:0] rounded down to a multiple of 2^s (off=0 for s=3). In little-endian order, register byte j appears on lane off+j, bits [8k+7:8k] being lane k.
- R3: With big_endian_i=1, register byte j of an element of n=2^s bytes is placed on lane off+n-1-j, for both loads and stores. For a 16-byte element, byte k of each 64-bit half maps to lane 7-k of its beat.
- R4: A store with size code 4 issues two beats with mem_be_o=8'hFF. The first beat goes to addr_i and carries register bits [63:0]; the second goes to addr_i+8 and carries bits [127:64].
- R5: A load with size code 0..3 reads one beat at addr_i and writes the register with the element in its low bytes, using the lane mapping of R2/R3, and with every bit above the element cleared up to bit 127.
- R6: A load with size code 4 reads one beat at addr_i and one at addr_i+8. It writes the register with the first beat in bits [63:0] and the second in bits [127:64].
- R7: reg_we_o is high for exactly one cycle per load, in the cycle that done_o is high. It is never high for a store or a rejected request.
- R8: done_o is high for exactly one cycle, in the cycle after the memory accepts the final beat (mem_req_o and mem_ack_i both high).
- R9: A start with size code 5, 6 or 7 raises no memory request, writes no register, and raises err_o together with done_o in the cycle after start_i.
- R10: mem_req_o, mem_addr_o, mem_be_o, mem_wdata_o and mem_we_o hold steady until mem_ack_i. A start_i pulse while busy_o is high is ignored.
- R11: An accepted start_i raises mem_req_o, with the first beat's address and data, in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted while not busy |
| load_i | input | 1 | 1 = load to register, 0 = store from register |
| size_i | input | 3 | Element size, log2 of byte count (0..4 legal) |
| big_endian_i | input | 1 | Reverse byte order within the element |
| addr_i | input | ADDR_W | Byte address of the element |
| reg_rdata_i | input | REG_W | Register value to store, sampled with start |
| reg_we_o | output | 1 | Register write strobe (loads) |
| reg_wdata_o | output | REG_W | Register write value, zero-extended |
| mem_req_o | output | 1 | Memory beat request, held until acknowledged |
| mem_we_o | output | 1 | Beat direction, 1 = write |
| mem_addr_o | output | ADDR_W | Beat byte address |
| mem_be_o | output | BEAT_W/8 | Byte lane enables |
| mem_wdata_o | output | BEAT_W | Write data for the beat |
| mem_ack_i | input | 1 | Memory accepts the current beat |
| mem_rdata_i | input | BEAT_W | Read data, valid with mem_ack_i |
| busy_o | output | 1 | A transfer is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion was a rejected size code |

## Verification
Each result has a fixed due cycle relative to a stimulus. The first request appears one cycle after the start edge. Each beat completes at the edge where request and acknowledge are both high. Done and the register write come one cycle after the final acknowledge. A rejected size gives err and done one cycle after start. The bench samples every output on the falling edge and numbers the cycles from the start edge. It records the cycle of the last acknowledge and requires done exactly one cycle later. It also checks the cycle after that, to confirm the pulse is a single cycle and that no stray start has begun a new transfer. Memory latency varies between 0 and 2 wait cycles, so these relations are checked under several beat spacings.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

  localparam int SZ_W = 3;

  typedef enum logic [0:0] {
    S_IDLE = 1'b0,
    S_XFER = 1'b1
  } vmx_state_e;

  typedef struct packed {
    logic              load;
    logic              big;
    logic [SZ_W-1:0]   size;
  } vmx_op_t;

  // Element size as seen inside one beat: anything wider than a beat
  // fills the beat completely.
  function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] s,
                                               input logic [SZ_W-1:0] lim);
    return (s > lim) ? lim : s;
  endfunction

endpackage

// File: rtl/vmx_byte_order.sv
// Per-lane permutation: keeps the low 2^sz bytes, optionally reversed,
// and clears every byte above the element.
module vmx_byte_order
  import vmx_pkg::*;
#(
  parameter int BEAT_W = 64
) (
  input  logic [BEAT_W-1:0] din_i,
  input  logic [SZ_W-1:0]   sz_i,
  input  logic              big_i,
  output logic [BEAT_W-1:0] dout_o
);

  localparam int NB = BEAT_W / 8;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [7:0] lane;
    always_comb begin
      int span;
      int src;
      span = 32'd1 << sz_i;
      src  = big_i ? (span - 1 - j) : j;
      lane = 8'h00;
      if (j < span) lane = din_i[src*8 +: 8];
    end
    assign dout_o[j*8 +: 8] = lane;
  end

endmodule

// File: rtl/vmx_store_path.sv
// Formats one outgoing beat: order the element bytes, then move them to
// their lane offset and build the matching byte enables.
module vmx_store_path
  import vmx_pkg::*;
#(
  parameter int BEAT_W = 64,
  parameter int LOG_NB = 3
) (
  input  logic [BEAT_W-1:0]   din_i,
  input  logic [SZ_W-1:0]     sz_i,
  input  logic                big_i,
  input  logic [LOG_NB-1:0]   off_i,
  output logic [BEAT_W-1:0]   wdata_o,
  output logic [BEAT_W/8-1:0] be_o
);

  localparam int NB = BEAT_W / 8;

  logic [BEAT_W-1:0] ordered;
  logic [NB-1:0]     elem_mask;

  vmx_byte_order #(.BEAT_W(BEAT_W)) u_order (
    .din_i (din_i),
    .sz_i  (sz_i),
    .big_i (big_i),
    .dout_o(ordered)
  );

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      elem_mask[k] = (k < (32'd1 << sz_i));
    end
    wdata_o = ordered << {off_i, 3'b000};
    be_o    = elem_mask << off_i;
  end

endmodule

// File: rtl/vmx_load_path.sv
// Extracts one incoming beat: move the element down from its lane offset,
// then order its bytes and zero everything above it.
module vmx_load_path
  import vmx_pkg::*;
#(
  parameter int BEAT_W = 64,
  parameter int LOG_NB = 3
) (
  input  logic [BEAT_W-1:0] din_i,
  input  logic [SZ_W-1:0]   sz_i,
  input  logic              big_i,
  input  logic [LOG_NB-1:0] off_i,
  output logic [BEAT_W-1:0] dout_o
);

  logic [BEAT_W-1:0] shifted;

  assign shifted = din_i >> {off_i, 3'b000};

  vmx_byte_order #(.BEAT_W(BEAT_W)) u_order (
    .din_i (shifted),
    .sz_i  (sz_i),
    .big_i (big_i),
    .dout_o(dout_o)
  );

endmodule

// File: rtl/vmx_ctrl.sv
// Sequencer: accepts a start, counts beats, and produces the registered
// done / error pulses.
module vmx_ctrl
  import vmx_pkg::*;
#(
  parameter int LOG_NB = 3,
  parameter int MAX_SZ = 4,
  parameter int BI_W   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            ack_i,
  output logic            req_o,
  output logic            busy_o,
  output logic [BI_W-1:0] beat_o,
  output logic            accept_o,
  output logic            advance_o,
  output logic            finish_o,
  output logic            done_o,
  output logic            err_o
);

  vmx_state_e      state_q;
  logic [BI_W-1:0] beat_q;
  logic [BI_W-1:0] last_q;
  logic [BI_W-1:0] last_nxt;
  logic            done_q;
  logic            err_q;
  logic            size_ok;
  logic            reject;
  logic            hit;
  logic            at_last;

  always_comb begin
    int span;
    size_ok  = int'(size_i) <= MAX_SZ;
    accept_o = (state_q == S_IDLE) && start_i && size_ok;
    reject   = (state_q == S_IDLE) && start_i && !size_ok;
    hit      = (state_q == S_XFER) && ack_i;
    at_last  = (beat_q == last_q);
    advance_o = hit && !at_last;
    finish_o  = hit && at_last;
    span = (int'(size_i) > LOG_NB) ? ((1 << (int'(size_i) - LOG_NB)) - 1) : 0;
    last_nxt = BI_W'(span);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= finish_o || reject;
      err_q  <= reject;
      if (accept_o) begin
        state_q <= S_XFER;
        beat_q  <= '0;
        last_q  <= last_nxt;
      end else if (advance_o) begin
        beat_q <= beat_q + 1'b1;
      end else if (finish_o) begin
        state_q <= S_IDLE;
      end
    end
  end

  assign req_o  = (state_q == S_XFER);
  assign busy_o = (state_q == S_XFER);
  assign beat_o = beat_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/vreg_mem_xfer.sv
module vreg_mem_xfer
  import vmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 128,
  parameter int BEAT_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                load_i,
  input  logic [SZ_W-1:0]     size_i,
  input  logic                big_endian_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    reg_rdata_i,
  output logic                reg_we_o,
  output logic [REG_W-1:0]    reg_wdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [BEAT_W/8-1:0] mem_be_o,
  output logic [BEAT_W-1:0]   mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [BEAT_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);

  localparam int NB     = BEAT_W / 8;
  localparam int LOG_NB = $clog2(NB);
  localparam int NBEAT  = REG_W / BEAT_W;
  localparam int BI_W   = (NBEAT > 1) ? $clog2(NBEAT) : 1;
  localparam int MAX_SZ = $clog2(REG_W / 8);
  localparam logic [SZ_W-1:0] LOG_NB_SZ = SZ_W'(LOG_NB);

  logic            accept;
  logic            advance;
  logic            finish;
  logic [BI_W-1:0] beat_idx;

  vmx_ctrl #(
    .LOG_NB(LOG_NB),
    .MAX_SZ(MAX_SZ),
    .BI_W  (BI_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .size_i   (size_i),
    .ack_i    (mem_ack_i),
    .req_o    (mem_req_o),
    .busy_o   (busy_o),
    .beat_o   (beat_idx),
    .accept_o (accept),
    .advance_o(advance),
    .finish_o (finish),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  // Captured request; data_q holds the store source or the load result.
  vmx_op_t           op_q;
  logic [ADDR_W-1:0] base_q;
  logic [REG_W-1:0]  data_q;
  logic [LOG_NB-1:0] off_q;

  // Next beat to present, taken from the start inputs on accept.
  logic [SZ_W-1:0]   cur_sz;
  logic [SZ_W-1:0]   cur_eff_sz;
  logic              cur_big;
  logic              cur_load;
  logic [ADDR_W-1:0] cur_base;
  logic [REG_W-1:0]  cur_data;
  logic [BI_W-1:0]   nxt_beat;
  logic [LOG_NB-1:0] cur_off;
  logic [BEAT_W-1:0] beat_src;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BEAT_W-1:0] st_wdata;
  logic [NB-1:0]     st_be;

  always_comb begin
    cur_sz     = accept ? size_i       : op_q.size;
    cur_big    = accept ? big_endian_i : op_q.big;
    cur_load   = accept ? load_i       : op_q.load;
    cur_base   = accept ? addr_i       : base_q;
    cur_data   = accept ? reg_rdata_i  : data_q;
    nxt_beat   = accept ? '0 : BI_W'(beat_idx + 1'b1);
    cur_eff_sz = clamp_sz(cur_sz, LOG_NB_SZ);
    cur_off    = cur_base[LOG_NB-1:0] & ({LOG_NB{1'b1}} << cur_sz);
    beat_src   = cur_data[nxt_beat*BEAT_W +: BEAT_W];
    nxt_addr   = cur_base + (ADDR_W'(nxt_beat) << LOG_NB);
  end

  vmx_store_path #(
    .BEAT_W(BEAT_W),
    .LOG_NB(LOG_NB)
  ) u_store (
    .din_i  (beat_src),
    .sz_i   (cur_eff_sz),
    .big_i  (cur_big),
    .off_i  (cur_off),
    .wdata_o(st_wdata),
    .be_o   (st_be)
  );

  logic [SZ_W-1:0]   ld_eff_sz;
  logic [BEAT_W-1:0] ld_beat;
  logic [REG_W-1:0]  ld_merged;

  assign ld_eff_sz = clamp_sz(op_q.size, LOG_NB_SZ);

  vmx_load_path #(
    .BEAT_W(BEAT_W),
    .LOG_NB(LOG_NB)
  ) u_load (
    .din_i (mem_rdata_i),
    .sz_i  (ld_eff_sz),
    .big_i (op_q.big),
    .off_i (off_q),
    .dout_o(ld_beat)
  );

  always_comb begin
    ld_merged = data_q;
    ld_merged[beat_idx*BEAT_W +: BEAT_W] = ld_beat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q        <= '0;
      base_q      <= '0;
      data_q      <= '0;
      off_q       <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= finish && op_q.load;
      if (accept) begin
        op_q.load <= load_i;
        op_q.big  <= big_endian_i;
        op_q.size <= size_i;
        base_q    <= addr_i;
        data_q    <= load_i ? '0 : reg_rdata_i;
        off_q     <= cur_off;
        mem_we_o  <= !load_i;
      end else if ((advance || finish) && op_q.load) begin
        data_q[beat_idx*BEAT_W +: BEAT_W] <= ld_beat;
      end
      if (accept || advance) begin
        mem_addr_o  <= nxt_addr;
        mem_be_o    <= st_be;
        mem_wdata_o <= cur_load ? '0 : st_wdata;
      end
      if (finish && op_q.load) begin
        reg_wdata_o <= ld_merged;
      end
    end
  end

endmodule

// File: rtl/vmx_checker.sv
module vmx_checker #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 128,
  parameter int BEAT_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic [2:0]          size_i,
  input logic                mem_req_o,
  input logic                mem_ack_i,
  input logic                mem_we_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [BEAT_W/8-1:0] mem_be_o,
  input logic [BEAT_W-1:0]   mem_wdata_o,
  input logic                reg_we_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                err_o
);

  localparam int MAX_SZ = $clog2(REG_W / 8);

  // R7: register write only alongside a successful completion
  p_wr_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |-> (done_o && !err_o));

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: a successful completion follows an accepted beat
  p_done_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> $past(mem_req_o && mem_ack_i));

  // R9: a rejected request touches neither memory nor register
  p_err_no_access_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && !mem_req_o && !reg_we_o && $past(!mem_req_o)));

  // R10: a pending beat holds every request field steady
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_wdata_o) && $stable(mem_be_o) && $stable(mem_we_o)));

  // R2: every request enables at least one lane
  p_be_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_be_o != '0));

  // R11: an accepted start requests memory in the next cycle
  p_req_after_start_r11: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (int'(size_i) <= MAX_SZ)) |=> mem_req_o);

endmodule

bind vreg_mem_xfer vmx_checker #(
  .ADDR_W(ADDR_W),
  .REG_W (REG_W),
  .BEAT_W(BEAT_W)
) u_vmx_checker (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .size_i     (size_i),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .mem_wdata_o(mem_wdata_o),
  .reg_we_o   (reg_we_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/vreg_mem_xfer_bench.sv
module vreg_mem_xfer_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         load_i = 1'b0;
  logic [2:0]   size_i = 3'd0;
  logic         big_endian_i = 1'b0;
  logic [31:0]  addr_i = 32'd0;
  logic [127:0] reg_rdata_i = '0;
  logic         reg_we_o;
  logic [127:0] reg_wdata_o;
  logic         mem_req_o;
  logic         mem_we_o;
  logic [31:0]  mem_addr_o;
  logic [7:0]   mem_be_o;
  logic [63:0]  mem_wdata_o;
  logic         mem_ack_i;
  logic [63:0]  mem_rdata_i;
  logic         busy_o;
  logic         done_o;
  logic         err_o;

  int checks = 0;
  int failures = 0;
  int lat_v = 0;

  always #4 clk = ~clk;

  vreg_mem_xfer u_vreg_mem_xfer (
    .clk(clk), .rst(rst), .start_i(start_i), .load_i(load_i),
    .size_i(size_i), .big_endian_i(big_endian_i), .addr_i(addr_i),
    .reg_rdata_i(reg_rdata_i), .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [63:0] pat(input int i);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'(i * 16 + k);
    return v;
  endfunction

  // Memory model: 16 words, ack after lat_v wait cycles, one cycle long.
  logic [63:0] mem [16];
  logic [63:0] shadow [16];
  int          wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ack_i   <= 1'b0;
      mem_rdata_i <= '0;
      wcnt        <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= pat(i);
    end else if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
      wcnt      <= 0;
    end else if (mem_req_o) begin
      if (wcnt >= lat_v) begin
        mem_ack_i   <= 1'b1;
        mem_rdata_i <= mem[mem_addr_o[6:3]];
        if (mem_we_o) begin
          for (int k = 0; k < 8; k++)
            if (mem_be_o[k]) mem[mem_addr_o[6:3]][k*8 +: 8] <= mem_wdata_o[k*8 +: 8];
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit ld, input int sz, input logic [31:0] addr,
                        input bit big, input logic [127:0] rv, input int lat,
                        input bit poke);
    int n, off, w, exp_beats, t, beats, writes, done_t, last_ack_t, dbl;
    bit err_case, done_seen, err_seen;
    logic [63:0]  nw0, nw1;
    logic [127:0] exp_reg, wdat;
    logic [7:0]   exp_be;
    logic [31:0]  baddr [2];
    logic [7:0]   bbe [2];
    logic         bwe [2];
    string tag;

    err_case  = (sz > 4);
    n         = 1 << ((sz > 3) ? 3 : sz);
    off       = (sz >= 3) ? 0 : (int'(addr[2:0]) & ~(n - 1));
    w         = int'(addr[6:3]);
    exp_beats = err_case ? 0 : ((sz == 4) ? 2 : 1);
    exp_be    = (sz >= 3) ? 8'hFF : 8'(((1 << n) - 1) << off);
    tag = (sz == 4) ? (ld ? "R6" : "R4") : (ld ? "R5" : "R2");
    if (big) tag = {tag, "/R3"};

    nw0 = shadow[w];
    nw1 = shadow[(w + 1) % 16];
    exp_reg = '0;
    for (int k = 0; k < 8; k++) begin
      if (sz == 4) begin
        int s4;
        s4 = big ? 7 - k : k;
        nw0[k*8 +: 8]        = rv[s4*8 +: 8];
        nw1[k*8 +: 8]        = rv[64 + s4*8 +: 8];
        exp_reg[k*8 +: 8]    = shadow[w][s4*8 +: 8];
        exp_reg[64+k*8 +: 8] = shadow[(w + 1) % 16][s4*8 +: 8];
      end else if (k >= off && k < off + n) begin
        int j;
        j = k - off;
        nw0[k*8 +: 8] = rv[(big ? n - 1 - j : j)*8 +: 8];
      end
      if (sz < 4 && k < n)
        exp_reg[k*8 +: 8] = shadow[w][(off + (big ? n - 1 - k : k))*8 +: 8];
    end

    lat_v = lat;
    beats = 0; writes = 0; done_t = -1; last_ack_t = -9; dbl = 0;
    done_seen = 0; err_seen = 0; wdat = '0;
    for (int b = 0; b < 2; b++) begin baddr[b] = '0; bbe[b] = '0; bwe[b] = 1'b0; end

    @(negedge clk);
    start_i = 1'b1; load_i = ld; size_i = 3'(sz); big_endian_i = big;
    addr_i = addr; reg_rdata_i = rv;
    for (t = 0; t < 60; t++) begin
      @(negedge clk);
      if (t == 0) begin
        start_i = 1'b0; reg_rdata_i = ~rv; addr_i = 32'hFFFF_FFF0;
        chk({127'd0, mem_req_o}, {127'd0, !err_case}, err_case ? "R9 no request" : "R11 request next cycle");
      end
      if (poke && t == 1) begin
        start_i = 1'b1; load_i = !ld; size_i = 3'd0; addr_i = 32'h78;
      end
      if (poke && t == 2) start_i = 1'b0;
      if (mem_req_o && mem_ack_i) begin
        if (beats < 2) begin baddr[beats] = mem_addr_o; bbe[beats] = mem_be_o; bwe[beats] = mem_we_o; end
        beats++;
        last_ack_t = t;
      end
      if (reg_we_o) begin writes++; wdat = reg_wdata_o; end
      if (done_o) begin
        if (done_seen) dbl++;
        else begin done_t = t; err_seen = err_o; done_seen = 1; end
      end
      if (done_seen && t == done_t + 2) break;
    end
    if (!done_seen) chk(0, 1, "R8 done never seen");

    chk({127'd0, mem_req_o}, 128'd0, "R10 no transfer after completion");
    chk(128'(dbl), 128'd0, "R8 done single pulse");
    chk(128'(beats), 128'(exp_beats), {tag, " beat count"});
    if (err_case) begin
      chk(128'(done_t), 128'd0, "R9 done one cycle after start");
      chk({127'd0, err_seen}, 128'd1, "R9 err with done");
      chk(128'(writes), 128'd0, "R9 no register write");
    end else begin
      chk({127'd0, err_seen}, 128'd0, "R8 no err on legal size");
      chk(128'(done_t), 128'(last_ack_t + 1), "R8 done after final ack");
      chk(128'(writes), 128'(ld ? 1 : 0), "R7 register write count");
      chk(128'(baddr[0]), 128'(addr), {tag, " first beat address"});
      chk(128'(bbe[0]), 128'(exp_be), {tag, " byte enables"});
      chk(128'(bwe[0]), 128'(!ld), {tag, " beat direction"});
      if (sz == 4) chk(128'(baddr[1]), 128'(addr + 32'd8), {tag, " second beat address"});
      if (ld) begin
        chk(wdat, exp_reg, {tag, " register value"});
      end else begin
        chk(128'(mem[w]), 128'(nw0), {tag, " memory word"});
        shadow[w] = nw0;
        if (sz == 4) begin
          chk(128'(mem[w + 1]), 128'(nw1), {tag, " high memory word"});
          shadow[w + 1] = nw1;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = pat(i);
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk({123'd0, mem_req_o, mem_we_o, reg_we_o, busy_o, done_o}, 128'd0, "R1 reset idle");
    rst = 1'b0;
    @(negedge clk);
    chk({123'd0, mem_req_o, reg_we_o, busy_o, done_o, err_o}, 128'd0, "R1 idle after reset");

    for (int sz = 0; sz <= 4; sz++)
      for (int big = 0; big < 2; big++)
        for (int ld = 0; ld < 2; ld++)
          for (int slot = 0; slot < ((sz < 3) ? (8 >> sz) : 1); slot++) begin
            int w;
            logic [127:0] rv;
            w  = (sz * 3 + slot + big * 5 + ld * 2) % 14;
            rv = {64'hF0E1_D2C3_B4A5_9687 ^ {8{8'(sz * 16 + slot)}},
                  64'h0123_4567_89AB_CDEF + 64'(slot * 977 + sz * 31 + big)};
            run_op(ld[0], sz, 32'(w * 8 + slot * (1 << sz)), big[0], rv,
                   (slot + sz + ld) % 3, 1'b0);
          end

    // R2/R5: low address bits finer than the element are rounded down
    run_op(1'b0, 2, 32'h25, 1'b0, 128'hAAAA_BBBB_CCCC_DDDD_1122_3344_5566_7788, 1, 1'b0);
    run_op(1'b1, 1, 32'h23, 1'b1, '0, 0, 1'b0);
    // R9: illegal sizes
    for (int sz = 5; sz < 8; sz++) run_op(sz[0], sz, 32'h10, 1'b0, '1, 0, 1'b0);
    // R10: start while busy is ignored
    run_op(1'b1, 4, 32'h40, 1'b1, '0, 2, 1'b1);
    run_op(1'b0, 4, 32'h30, 1'b0, 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100, 2, 1'b1);
    run_op(1'b0, 0, 32'h57, 1'b1, 128'h5A, 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule